// File: doc/BRIEF.md
# Two-Path Cascaded CIC Decimator

This block reduces the sample rate of a complex baseband stream by exactly 64. Samples arrive one at a time on a valid/ready input. Each sample carries a tag that says whether it belongs to the in-phase (I) path or the quadrature (Q) path, and an I sample followed by a Q sample forms one pair. Each path has its own chain of three cascaded CIC decimators. Every stage has four integrators and four combs with a differential delay of one, and every stage decimates by four.

A single packed counter controls both paths. The counter has one base-4 digit per stage, and each digit carries into the next when it wraps. The counter decides on which accepted pair each stage produces an output: every 4th pair for the first stage, every 16th for the second and every 64th for the third. The I and Q results of the last stage are rounded to the output width and loaded into a holding register. That register drives one valid/ready output beat per 64 pairs. While the held result is waiting, the input stalls, so no output is ever dropped or repeated.

Top module: `iq_cic_decim`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every integrator, comb delay, schedule digit and the pairing state. Afterwards out_valid is 0 and in_ready is 1. The next output equals that of a freshly started filter.
- R2: in_is_q = 0 tags an I sample and in_is_q = 1 tags a Q sample. A pair is an I sample followed by a Q sample. A sample whose tag does not match the expected one is accepted (in_ready stays as usual) and discarded without effect.
- R3: Each stage has four cascaded integrators, updated on each of its input samples. It also has four combs of differential delay 1, evaluated on every 4th input sample. Arithmetic is two's complement with wraparound at widths of 24, 32 and 40 bits for stages one to three. Each stage's input is sign-extended to its width.
- R4: The 40-bit final value is reduced to 24 bits by keeping bits 39:16. It is rounded to nearest with ties to even, using bits 15:0, and wraps on overflow.
- R5: Exactly one output beat is produced per 64 accepted pairs. Stage one fires on pairs 4, 8, …, stage two on pairs 16, 32, …, and stage three on pairs 64, 128, …, all counted from reset.
- R6: out_valid rises after the 4th rising edge, counting the edge that accepts the Q sample of the 64th pair.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_i and out_q hold steady. out_valid falls in the cycle after a handshake.
- R8: in_ready is 0 exactly when out_valid is 1 and out_ready is 0.
- R9: The I result depends only on the I samples, and the Q result depends only on the Q samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high together with in_valid |
| in_is_q | input | 1 | Sample tag: 0 = I, 1 = Q |
| in_data | input | IN_W (16) | Signed input sample |
| out_valid | output | 1 | Held result pair valid |
| out_ready | input | 1 | Downstream accepts the held pair |
| out_i | output | OUT_W (24) | Signed decimated I result |
| out_q | output | OUT_W (24) | Signed decimated Q result |

## Verification
The bench builds the block with its default parameters: 16-bit input, 24-bit output, three stages of order four, rate four and tie-to-even rounding. With these values one output frame is only 64 pairs long, so impulse transients, step settling over six frames and several pseudo-random frames all fit in a short run. Constant full-scale negative and positive inputs drive the 40-bit final stage to the extremes of the output range. A cycle-exact latency check, a stray-tag sequence, a mid-frame reset and a held-output stall exercise the scheduling counter, the pairing logic and the holding register.

// File: rtl/iq_cic_pkg.sv
package iq_cic_pkg;

   typedef enum logic {
      PATH_I = 1'b0,
      PATH_Q = 1'b1
   } iq_path_e;

   // Output width of stage s (0-based): input width plus growth of s+1 stages.
   function automatic int stage_out_w(input int in_w, input int s, input int grow);
      return in_w + (s + 1) * grow;
   endfunction

   // Bit offset of stage s output inside a flat bus holding all stage outputs.
   function automatic int stage_bus_off(input int in_w, input int s, input int grow);
      return s * in_w + grow * ((s * (s + 1)) / 2);
   endfunction

endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
   import iq_cic_pkg::*;
#(
   parameter int STAGES = 3,
   parameter int RL2    = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire,
   input  logic              tag_q,
   output logic              take_i,
   output logic              take_q,
   output logic [STAGES-1:0] dec_mask
);

   logic                           expect_q;
   logic [STAGES-1:0][RL2-1:0]     digits;
   logic [STAGES-1:0]              at_max;
   logic [STAGES-1:0]              carry_in;

   assign take_i = fire && (iq_path_e'(tag_q) == PATH_I) && !expect_q;
   assign take_q = fire && (iq_path_e'(tag_q) == PATH_Q) && expect_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         expect_q <= 1'b0;
      end else if (take_i) begin
         expect_q <= 1'b1;
      end else if (take_q) begin
         expect_q <= 1'b0;
      end
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_dig
      assign at_max[g] = &digits[g];
      if (g == 0) begin : g_low
         assign dec_mask[g] = at_max[g];
         assign carry_in[g] = 1'b1;
      end else begin : g_up
         assign dec_mask[g] = dec_mask[g-1] & at_max[g];
         assign carry_in[g] = dec_mask[g-1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         digits <= '0;
      end else begin
         for (int g = 0; g < STAGES; g++) begin
            if (take_q && carry_in[g]) begin
               digits[g] <= digits[g] + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/cic_stage.sv
module cic_stage #(
   parameter int  IW    = 16,
   parameter int  ORDER = 4,
   parameter int  RL2   = 2,
   localparam int OW    = IW + ORDER * RL2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_en,
   input  logic          in_dec,
   input  logic [IW-1:0] in_data,
   output logic          out_en,
   output logic [OW-1:0] out_data
);

   logic [OW-1:0] acc_q [ORDER];
   logic [OW-1:0] acc_d [ORDER];
   logic [OW-1:0] dly_q [ORDER];
   logic [OW-1:0] cin   [ORDER];
   logic [OW-1:0] comb_out;

   always_comb begin
      logic [OW-1:0] run;
      run = OW'($signed(in_data));
      for (int k = 0; k < ORDER; k++) begin
         run      = acc_q[k] + run;
         acc_d[k] = run;
      end
      for (int k = 0; k < ORDER; k++) begin
         cin[k] = run;
         run    = run - dly_q[k];
      end
      comb_out = run;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < ORDER; k++) begin
            acc_q[k] <= '0;
            dly_q[k] <= '0;
         end
         out_en   <= 1'b0;
         out_data <= '0;
      end else begin
         out_en <= 1'b0;
         if (in_en) begin
            for (int k = 0; k < ORDER; k++) begin
               acc_q[k] <= acc_d[k];
            end
            if (in_dec) begin
               for (int k = 0; k < ORDER; k++) begin
                  dly_q[k] <= cin[k];
               end
               out_data <= comb_out;
               out_en   <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/cic_round.sv
module cic_round #(
   parameter int FW         = 40,
   parameter int OUTW       = 24,
   parameter bit ROUND_EVEN = 1'b1
) (
   input  logic [FW-1:0]   full,
   output logic [OUTW-1:0] rounded
);

   localparam int SH = FW - OUTW;

   logic [OUTW-1:0] keep;
   assign keep = full[FW-1 -: OUTW];

   if (ROUND_EVEN && SH >= 2) begin : g_even
      logic half;
      logic sticky;
      logic up;
      assign half    = full[SH-1];
      assign sticky  = |full[SH-2:0];
      assign up      = half & (sticky | keep[0]);
      assign rounded = keep + OUTW'(up);
   end else begin : g_trunc
      assign rounded = keep;
   end

endmodule

// File: rtl/cic_path.sv
module cic_path
   import iq_cic_pkg::*;
#(
   parameter int IW         = 16,
   parameter int OUTW       = 24,
   parameter int STAGES     = 3,
   parameter int ORDER      = 4,
   parameter int RL2        = 2,
   parameter bit ROUND_EVEN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_en,
   input  logic [STAGES-1:0] in_mask,
   input  logic [IW-1:0]     in_data,
   output logic              out_en,
   output logic [OUTW-1:0]   out_data
);

   localparam int GROW  = ORDER * RL2;
   localparam int FW    = IW + STAGES * GROW;
   localparam int TOTAL = stage_bus_off(IW, STAGES, GROW);
   localparam int LOFF  = stage_bus_off(IW, STAGES - 1, GROW);

   logic [TOTAL-1:0]  so_bus;
   logic [STAGES-1:0] en_bus;

   for (genvar s = 0; s < STAGES; s++) begin : g_st
      localparam int SW  = IW + s * GROW;
      localparam int OW  = stage_out_w(IW, s, GROW);
      localparam int OFF = stage_bus_off(IW, s, GROW);

      logic [SW-1:0] sin;
      logic          sin_en;
      logic          sdec;

      if (s == 0) begin : g_head
         assign sin    = in_data;
         assign sin_en = in_en;
         assign sdec   = in_mask[0];
      end else begin : g_link
         localparam int PW   = IW + (s - 1) * GROW + GROW;
         localparam int POFF = stage_bus_off(IW, s - 1, GROW);
         logic [s-1:0] dly_mask;
         always_ff @(posedge clk) begin
            if (rst) begin
               dly_mask <= '0;
            end else begin
               dly_mask <= s'({dly_mask, in_mask[s]});
            end
         end
         assign sin    = so_bus[POFF +: PW];
         assign sin_en = en_bus[s-1];
         assign sdec   = dly_mask[s-1];
      end

      cic_stage #(
         .IW    (SW),
         .ORDER (ORDER),
         .RL2   (RL2)
      ) u_stage (
         .clk      (clk),
         .rst      (rst),
         .in_en    (sin_en),
         .in_dec   (sdec),
         .in_data  (sin),
         .out_en   (en_bus[s]),
         .out_data (so_bus[OFF +: OW])
      );
   end

   cic_round #(
      .FW         (FW),
      .OUTW       (OUTW),
      .ROUND_EVEN (ROUND_EVEN)
   ) u_round (
      .full    (so_bus[LOFF +: FW]),
      .rounded (out_data)
   );

   assign out_en = en_bus[STAGES-1];

endmodule

// File: rtl/iq_cic_decim.sv
module iq_cic_decim #(
   parameter int IN_W       = 16,
   parameter int OUT_W      = 24,
   parameter int STAGES     = 3,
   parameter int ORDER      = 4,
   parameter int RATE_LOG2  = 2,
   parameter bit ROUND_EVEN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             in_is_q,
   input  logic [IN_W-1:0]  in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [OUT_W-1:0] out_i,
   output logic [OUT_W-1:0] out_q
);

   localparam int FULL_W = IN_W + STAGES * ORDER * RATE_LOG2;
   localparam int NPATH  = 2;

   initial begin
      assert (STAGES >= 1) else $fatal(1, "STAGES must be at least 1");
      assert (ORDER >= 1) else $fatal(1, "ORDER must be at least 1");
      assert (RATE_LOG2 >= 1) else $fatal(1, "RATE_LOG2 must be at least 1");
      assert (OUT_W <= FULL_W) else $fatal(1, "OUT_W exceeds full width");
      assert (!ROUND_EVEN || (FULL_W - OUT_W >= 2))
         else $fatal(1, "rounding needs two discarded bits");
   end

   logic              take_i;
   logic              take_q;
   logic [STAGES-1:0] dec_mask;
   logic [NPATH-1:0]  path_en;
   logic [NPATH-1:0]  fin_en;
   logic [OUT_W-1:0]  fin_dat [NPATH];

   assign in_ready = !out_valid || out_ready;

   cic_ctrl #(
      .STAGES (STAGES),
      .RL2    (RATE_LOG2)
   ) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .fire     (in_valid && in_ready),
      .tag_q    (in_is_q),
      .take_i   (take_i),
      .take_q   (take_q),
      .dec_mask (dec_mask)
   );

   assign path_en = {take_q, take_i};

   for (genvar p = 0; p < NPATH; p++) begin : g_path
      cic_path #(
         .IW         (IN_W),
         .OUTW       (OUT_W),
         .STAGES     (STAGES),
         .ORDER      (ORDER),
         .RL2        (RATE_LOG2),
         .ROUND_EVEN (ROUND_EVEN)
      ) u_path (
         .clk      (clk),
         .rst      (rst),
         .in_en    (path_en[p]),
         .in_mask  (dec_mask),
         .in_data  (in_data),
         .out_en   (fin_en[p]),
         .out_data (fin_dat[p])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
      end else begin
         if (out_valid && out_ready) begin
            out_valid <= 1'b0;
         end
         if (fin_en[0]) begin
            out_i <= fin_dat[0];
         end
         if (fin_en[1]) begin
            out_q     <= fin_dat[1];
            out_valid <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/iq_cic_decim_chk.sv
module iq_cic_decim_chk #(
   parameter int OUT_W     = 24,
   parameter int STAGES    = 3,
   parameter int RATE_LOG2 = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [OUT_W-1:0] out_i,
   input logic [OUT_W-1:0] out_q
);

   localparam int FRAME   = 1 << (STAGES * RATE_LOG2);
   localparam int MIN_GAP = 2 * FRAME - 1;
   localparam int GW      = $clog2(MIN_GAP + 2) + 1;

   logic [GW-1:0] gap;
   logic          prev_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap        <= '0;
         prev_valid <= 1'b0;
      end else begin
         prev_valid <= out_valid;
         if (out_valid && !prev_valid) begin
            gap <= '0;
         end else if (gap != '1) begin
            gap <= gap + 1'b1;
         end
      end
   end

   p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

   // R5: no two output frames closer than one full decimation frame of pairs
   p_rate_gap_r5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !prev_valid) |-> (gap >= GW'(MIN_GAP)));

   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)));

   p_release_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready) |=> !out_valid);

   p_stall_r8: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

   p_ready_r8: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready);

endmodule

bind iq_cic_decim iq_cic_decim_chk #(
   .OUT_W     (OUT_W),
   .STAGES    (STAGES),
   .RATE_LOG2 (RATE_LOG2)
) u_chk (.*);

// File: tb/iq_cic_decim_bench.sv
module iq_cic_decim_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        in_is_q = 1'b0;
   logic [15:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [23:0] out_i;
   logic [23:0] out_q;

   int n_run  = 0;
   int n_fail = 0;
   int unsigned seed = 32'h1234_5678;

   logic signed [23:0] got_i[$];
   logic signed [23:0] got_q[$];
   longint exp_i[$];
   longint exp_q[$];

   longint m_acc [2][3][4];
   longint m_dly [2][3][4];
   int     m_cnt [2][3];

   always #4 clk = ~clk;

   iq_cic_decim u_iq_cic_decim (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_is_q   (in_is_q),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_i     (out_i),
      .out_q     (out_q)
   );

   always @(negedge clk) begin
      if (!rst && out_valid && out_ready) begin
         got_i.push_back(out_i);
         got_q.push_back(out_q);
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "WATCHDOG", "run did not end", 0, 1);
      finish_run();
   end

   function automatic longint wrapw(input longint v, input int w);
      longint t;
      t = v <<< (64 - w);
      return t >>> (64 - w);
   endfunction

   function automatic logic [15:0] rnd16();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed[30:15];
   endfunction

   task automatic model_reset();
      for (int p = 0; p < 2; p++)
         for (int s = 0; s < 3; s++) begin
            m_cnt[p][s] = 0;
            for (int k = 0; k < 4; k++) begin
               m_acc[p][s][k] = 0;
               m_dly[p][s][k] = 0;
            end
         end
      exp_i.delete();
      exp_q.delete();
      got_i.delete();
      got_q.delete();
   endtask

   // R3/R4/R5: textbook cascade of three N=4, R=4 stages, then round-half-even
   task automatic model_step(input int p, input longint x);
      longint v, c, t, keep, rem;
      int w;
      v = x;
      for (int s = 0; s < 3; s++) begin
         w = 24 + 8 * s;
         m_acc[p][s][0] = wrapw(m_acc[p][s][0] + v, w);
         for (int k = 1; k < 4; k++)
            m_acc[p][s][k] = wrapw(m_acc[p][s][k] + m_acc[p][s][k-1], w);
         m_cnt[p][s]++;
         if (m_cnt[p][s] != 4) return;
         m_cnt[p][s] = 0;
         c = m_acc[p][s][3];
         for (int k = 0; k < 4; k++) begin
            t = c;
            c = wrapw(c - m_dly[p][s][k], w);
            m_dly[p][s][k] = t;
         end
         v = c;
      end
      keep = v >>> 16;
      rem  = v & 64'hFFFF;
      if (rem > 32768 || (rem == 32768 && (keep & 1) != 0)) keep = keep + 1;
      keep = wrapw(keep, 24);
      if (p == 0) exp_i.push_back(keep);
      else        exp_q.push_back(keep);
   endtask

   task automatic do_reset();
      @(posedge clk);
      #1;
      rst = 1'b1;
      in_valid = 1'b0;
      out_ready = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      rst = 1'b0;
      model_reset();
   endtask

   task automatic push(input logic q, input logic [15:0] d);
      @(negedge clk);
      in_valid = 1'b1;
      in_is_q  = q;
      in_data  = d;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic push_pair(input logic [15:0] di, input logic [15:0] dq);
      push(1'b0, di);
      model_step(0, longint'($signed(di)));
      push(1'b1, dq);
      model_step(1, longint'($signed(dq)));
   endtask

   task automatic compare_out(input string req, input int n_expect);
      repeat (8) @(negedge clk);
      check(got_i.size() == n_expect, req, "output beat count", got_i.size(), n_expect);
      check(exp_i.size() == n_expect, req, "model beat count", exp_i.size(), n_expect);
      for (int k = 0; k < n_expect && k < got_i.size() && k < exp_i.size(); k++) begin
         check(longint'(got_i[k]) == exp_i[k], req, $sformatf("out_i beat %0d", k),
               longint'(got_i[k]), exp_i[k]);
         check(longint'(got_q[k]) == exp_q[k], req, $sformatf("out_q beat %0d", k),
               longint'(got_q[k]), exp_q[k]);
      end
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
   endtask

   // R6 latency, R3 impulse response over three frames
   task automatic t_impulse_latency();
      do_reset();
      for (int k = 0; k < 64; k++) begin
         if (k == 0) push_pair(16'd1000, -16'sd500);
         else        push_pair(16'd0, 16'd0);
      end
      for (int c = 1; c <= 4; c++) begin
         @(negedge clk);
         check(out_valid == (c == 4), "R6", $sformatf("out_valid %0d edges after last Q", c),
               out_valid, (c == 4));
      end
      for (int k = 0; k < 128; k++) push_pair(16'd0, 16'd0);
      compare_out("R3", 3);
   endtask

   task automatic t_step();
      do_reset();
      for (int k = 0; k < 6 * 64; k++) push_pair(16'd1234, -16'sd777);
      compare_out("R3", 6);
      if (got_i.size() == 6) begin
         check(longint'(got_i[5]) == 315904, "R3", "settled I step", longint'(got_i[5]), 315904);
         check(longint'(got_q[5]) == -198912, "R3", "settled Q step", longint'(got_q[5]), -198912);
      end
   endtask

   task automatic t_pattern();
      do_reset();
      for (int k = 0; k < 5 * 64; k++) push_pair(rnd16(), rnd16());
      compare_out("R4", 5);
      check(got_i.size() == 5, "R5", "exactly five beats for 320 pairs", got_i.size(), 5);
   endtask

   task automatic t_fullscale();
      do_reset();
      for (int k = 0; k < 4 * 64; k++) push_pair(16'h8000, 16'h7FFF);
      compare_out("R3", 4);
      if (got_i.size() == 4) begin
         check(longint'(got_i[3]) == -8388608, "R4", "negative full scale", longint'(got_i[3]), -8388608);
         check(longint'(got_q[3]) == 8388352, "R4", "positive full scale", longint'(got_q[3]), 8388352);
      end
   endtask

   task automatic t_tags();
      do_reset();
      push(1'b1, 16'd500);
      for (int k = 0; k < 64; k++) begin
         logic [15:0] a, b;
         a = rnd16();
         b = rnd16();
         push(1'b0, a);
         model_step(0, longint'($signed(a)));
         if (k == 10) push(1'b0, 16'd9999);
         if (k == 30) push(1'b0, 16'h8000);
         push(1'b1, b);
         model_step(1, longint'($signed(b)));
         if (k == 50) push(1'b1, 16'h7777);
      end
      compare_out("R2", 1);
   endtask

   task automatic t_independence();
      do_reset();
      for (int k = 0; k < 2 * 64; k++) push_pair(16'd0, rnd16());
      compare_out("R9", 2);
      for (int k = 0; k < got_i.size(); k++)
         check(got_i[k] == 24'sd0, "R9", "I stays zero under Q activity", longint'(got_i[k]), 0);
   endtask

   task automatic t_stall();
      logic [23:0] hi, hq;
      do_reset();
      @(posedge clk);
      #1 out_ready = 1'b0;
      for (int k = 0; k < 64; k++) push_pair(rnd16(), rnd16());
      repeat (6) @(negedge clk);
      check(out_valid == 1'b1, "R7", "result held while not ready", out_valid, 1);
      check(in_ready == 1'b0, "R8", "input stalled by held result", in_ready, 0);
      hi = out_i;
      hq = out_q;
      repeat (5) @(negedge clk);
      check(out_valid == 1'b1 && out_i == hi && out_q == hq, "R7", "held pair stable",
            {out_i, out_q}, {hi, hq});
      check(in_ready == 1'b0, "R8", "still stalled", in_ready, 0);
      @(posedge clk);
      #1 out_ready = 1'b1;
      #1;
      check(in_ready == 1'b1, "R8", "ready follows out_ready", in_ready, 1);
      @(negedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R7", "valid drops after handshake", out_valid, 0);
      compare_out("R7", 1);
   endtask

   task automatic t_midreset();
      do_reset();
      for (int k = 0; k < 30; k++) push_pair(rnd16(), rnd16());
      do_reset();
      for (int k = 0; k < 64; k++) push_pair(rnd16(), rnd16());
      compare_out("R1", 1);
   endtask

   initial begin
      t_reset();
      t_impulse_latency();
      t_step();
      t_pattern();
      t_fullscale();
      t_tags();
      t_independence();
      t_stall();
      t_midreset();
      finish_run();
   end

endmodule